// File: doc/BRIEF.md
# Debug Event Status Register

This block holds the sticky record of debug events for a processor core. Single-cycle event pulses from the address comparators set individual status bits. The bits stay set until software clears them. Four instruction-address-compare hits and the read and write hits of two data-address comparators each have their own bit. A summary flag records that some event arrived while debug interrupts were switched off. A two-bit field keeps the cause of the most recent reset.

Software reaches the register through the special-purpose register access ports, at register number 1008 (0x3F0). A move-from access returns the value combinationally. A move-to access cannot load a value. It can only clear: every data bit that is 1 clears the matching status bit. Both ports are honoured only in privileged mode. An unprivileged access to the register changes nothing and raises a one-cycle violation pulse.

Top module: `dbg_event_status`

## Requirements
- R1: When `spr_rd` is 1, `spr_priv` is 1 and `spr_num` equals 1008, `spr_rdata` shows the register. In every other case `spr_rdata` is 0.
- R2: Bits 31:27, 17:10 and 7:0 of the read value (LSB-0 numbering) always read 0.
- R3: An event pulse sets its bit, and the bit reads as 1 from the next cycle until it is cleared. The bit positions (LSB-0) are: IAC1 26, IAC2 25, DAC1-read 24, DAC1-write 23, DAC2-read 22, DAC2-write 21, IAC3 19, IAC4 18.
- R4: A privileged write to number 1008 clears every implemented bit whose data bit is 1 and leaves the other bits unchanged. A write never sets a bit.
- R5: If an event and a clear hit the same bit in the same cycle, the bit is 1 afterwards.
- R6: Bit 20 (imprecise flag) is set when any event pulse arrives while `dbg_en` is 0. Pulses that arrive while `dbg_en` is 1 do not set it.
- R7: A clock edge with `rst_n` low clears all event bits and loads bits 9:8 from `rst_cause`. The codes are 00 none, 01 processor, 10 chip, 11 system. Software can clear bits 9:8 like the event bits.
- R8: A read or write to number 1008 with `spr_priv` at 0 leaves the register unchanged and reads as 0. `priv_viol` is 1 in the cycle after each such access and 0 otherwise.
- R9: Accesses to any other register number leave the register unchanged and never raise `priv_viol`.
- R10: A read returns the value held before any set or clear applied in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rst_cause | input | 2 | Reset cause code, loaded during reset |
| dbg_en | input | 1 | Debug interrupts enabled |
| evt_iac | input | 4 | Instruction compare hit pulses, index 0 is IAC1 |
| evt_dac_rd | input | 2 | Data compare read hit pulses, index 0 is DAC1 |
| evt_dac_wr | input | 2 | Data compare write hit pulses, index 0 is DAC1 |
| spr_priv | input | 1 | Access is made in privileged mode |
| spr_rd | input | 1 | Move-from access strobe |
| spr_wr | input | 1 | Move-to (clear) access strobe |
| spr_num | input | 10 | Register number of the access |
| spr_wdata | input | 32 | Clear mask of a move-to access |
| spr_rdata | output | 32 | Read data, 0 when not selected |
| priv_viol | output | 1 | One-cycle pulse after an unprivileged access |

## Verification
A status bit that is lost, stuck or placed in the wrong position shows up on the very next privileged read, because reads are combinational. The random stream reads in most cycles, so such an error is found within a few cycles of its cause. A wrong set-versus-clear priority or a missed privilege gate leaves a value that differs from the bench model on the following read. A wrong violation pulse shows up one cycle after the access that caused it.

// File: rtl/dbsr_pkg.sv
package dbsr_pkg;
   localparam int unsigned REG_W = 32;

   // Positions are given in MSB-0 numbering and converted here.
   function automatic int unsigned msb0(input int unsigned n);
      return REG_W - 1 - n;
   endfunction

   function automatic int unsigned iac_bit(input int unsigned i);
      case (i)
         0: return msb0(5);
         1: return msb0(6);
         2: return msb0(12);
         default: return msb0(13);
      endcase
   endfunction

   function automatic int unsigned dac_rd_bit(input int unsigned i);
      return (i == 0) ? msb0(7) : msb0(9);
   endfunction

   function automatic int unsigned dac_wr_bit(input int unsigned i);
      return (i == 0) ? msb0(8) : msb0(10);
   endfunction

   localparam int unsigned IMPRECISE_BIT = REG_W - 1 - 11;
   localparam int unsigned RCAUSE_HI     = REG_W - 1 - 22;
   localparam int unsigned RCAUSE_LO     = REG_W - 1 - 23;

   localparam logic [REG_W-1:0] EVT_MASK    = 32'h07FC_0000;
   localparam logic [REG_W-1:0] RCAUSE_MASK = 32'h0000_0300;
   localparam logic [REG_W-1:0] IMPL_MASK   = EVT_MASK | RCAUSE_MASK;
endpackage

// File: rtl/dbsr_bit.sv
module dbsr_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic init_i,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n) q <= init_i;
      else        q <= set_i | (q & ~clr_i);
   end

   // R5
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q);
   // R4
   clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q);
   // R4
   no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !q) |=> !q);
endmodule

// File: rtl/dbsr_setmap.sv
module dbsr_setmap #(
   parameter int unsigned N_IAC = 4,
   parameter int unsigned N_DAC = 2
) (
   input  logic [N_IAC-1:0]          evt_iac,
   input  logic [N_DAC-1:0]          evt_rd,
   input  logic [N_DAC-1:0]          evt_wr,
   input  logic                      dbg_en,
   output logic [dbsr_pkg::REG_W-1:0] set_vec
);
   import dbsr_pkg::*;

   logic any_evt;
   assign any_evt = (|evt_iac) | (|evt_rd) | (|evt_wr);

   always_comb begin
      set_vec = '0;
      for (int unsigned i = 0; i < N_IAC; i++)
         set_vec[iac_bit(i)] = evt_iac[i];
      for (int unsigned j = 0; j < N_DAC; j++) begin
         set_vec[dac_rd_bit(j)] = evt_rd[j];
         set_vec[dac_wr_bit(j)] = evt_wr[j];
      end
      set_vec[IMPRECISE_BIT] = any_evt & ~dbg_en;
   end
endmodule

// File: rtl/dbsr_access.sv
module dbsr_access #(
   parameter int unsigned NUM_W          = 10,
   parameter int unsigned SPR_ADDR       = 1008,
   parameter bit          VIOL_REGISTERED = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       spr_priv,
   input  logic                       spr_rd,
   input  logic                       spr_wr,
   input  logic [NUM_W-1:0]           spr_num,
   input  logic [dbsr_pkg::REG_W-1:0] spr_wdata,
   output logic                       rd_en,
   output logic [dbsr_pkg::REG_W-1:0] clr_mask,
   output logic                       viol
);
   localparam logic [NUM_W-1:0] ADDR = NUM_W'(SPR_ADDR);

   logic hit, bad_acc;
   assign hit     = (spr_num == ADDR);
   assign rd_en   = hit & spr_rd & spr_priv;
   assign clr_mask = (hit & spr_wr & spr_priv) ? spr_wdata : '0;
   assign bad_acc = hit & (spr_rd | spr_wr) & ~spr_priv;

   generate
      if (VIOL_REGISTERED) begin : g_viol_reg
         logic viol_q;
         always_ff @(posedge clk) begin
            if (!rst_n) viol_q <= 1'b0;
            else        viol_q <= bad_acc;
         end
         assign viol = viol_q;
      end else begin : g_viol_comb
         assign viol = bad_acc;
      end
   endgenerate
endmodule

// File: rtl/dbg_event_status.sv
module dbg_event_status #(
   parameter int unsigned SPR_NUM_W       = 10,
   parameter int unsigned SPR_ADDR        = 1008,
   parameter int unsigned N_IAC           = 4,
   parameter int unsigned N_DAC           = 2,
   parameter int unsigned DATA_W          = 32,
   parameter bit          VIOL_REGISTERED = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           rst_cause,
   input  logic                 dbg_en,
   input  logic [N_IAC-1:0]     evt_iac,
   input  logic [N_DAC-1:0]     evt_dac_rd,
   input  logic [N_DAC-1:0]     evt_dac_wr,
   input  logic                 spr_priv,
   input  logic                 spr_rd,
   input  logic                 spr_wr,
   input  logic [SPR_NUM_W-1:0] spr_num,
   input  logic [DATA_W-1:0]    spr_wdata,
   output logic [DATA_W-1:0]    spr_rdata,
   output logic                 priv_viol
);
   import dbsr_pkg::*;

   localparam logic [SPR_NUM_W-1:0] ADDR = SPR_NUM_W'(SPR_ADDR);

   generate
      if (DATA_W != REG_W) begin : g_bad_width
         $error("dbg_event_status: DATA_W must equal 32");
      end
      if (N_IAC != 4 || N_DAC != 2) begin : g_bad_count
         $error("dbg_event_status: layout fixes 4 IAC and 2 DAC sources");
      end
      if (SPR_ADDR >= (1 << SPR_NUM_W)) begin : g_bad_addr
         $error("dbg_event_status: SPR_ADDR does not fit SPR_NUM_W");
      end
   endgenerate

   logic [REG_W-1:0] set_vec, clr_mask, status_q, init_vec;
   logic             rd_en;

   dbsr_setmap #(.N_IAC(N_IAC), .N_DAC(N_DAC)) u_setmap (
      .evt_iac (evt_iac),
      .evt_rd  (evt_dac_rd),
      .evt_wr  (evt_dac_wr),
      .dbg_en  (dbg_en),
      .set_vec (set_vec)
   );

   dbsr_access #(
      .NUM_W(SPR_NUM_W), .SPR_ADDR(SPR_ADDR), .VIOL_REGISTERED(VIOL_REGISTERED)
   ) u_access (
      .clk       (clk),
      .rst_n     (rst_n),
      .spr_priv  (spr_priv),
      .spr_rd    (spr_rd),
      .spr_wr    (spr_wr),
      .spr_num   (spr_num),
      .spr_wdata (spr_wdata),
      .rd_en     (rd_en),
      .clr_mask  (clr_mask),
      .viol      (priv_viol)
   );

   always_comb begin
      init_vec = '0;
      init_vec[RCAUSE_HI] = rst_cause[1];
      init_vec[RCAUSE_LO] = rst_cause[0];
   end

   for (genvar b = 0; b < REG_W; b++) begin : g_bit
      if (IMPL_MASK[b]) begin : g_impl
         dbsr_bit u_bit (
            .clk    (clk),
            .rst_n  (rst_n),
            .init_i (init_vec[b]),
            .set_i  (set_vec[b]),
            .clr_i  (clr_mask[b]),
            .q      (status_q[b])
         );
      end else begin : g_rsvd
         assign status_q[b] = 1'b0;
      end
   end

   assign spr_rdata = rd_en ? status_q : '0;

   logic no_evt;
   assign no_evt = ~(|evt_iac) & ~(|evt_dac_rd) & ~(|evt_dac_wr);

   // R2
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spr_rdata & ~IMPL_MASK) == '0);
   // R2
   setmap_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec & ~IMPL_MASK) == '0);
   // R6
   imprecise_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!no_evt && !dbg_en) |=> status_q[IMPRECISE_BIT]);
   // R8
   clear_needs_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask != '0) |-> (spr_priv && spr_wr && spr_num == ADDR));
   // R9
   untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (no_evt && (!spr_priv || !spr_wr || spr_num != ADDR)) |=> $stable(status_q));
   // R7
   reset_load_chk: assert property (@(posedge clk)
      !rst_n |=> (status_q[RCAUSE_HI:RCAUSE_LO] == $past(rst_cause)
                  && (status_q & EVT_MASK) == '0));
endmodule

// File: tb/dbg_event_status_tb.sv
`timescale 1ns/1ps
module dbg_event_status_tb;
   localparam logic [9:0]  ADDR = 10'd1008;
   localparam logic [31:0] IMPL = 32'h07FC_0300;
   localparam logic [31:0] EVTM = 32'h07FC_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  rst_cause = 2'b00;
   logic        dbg_en = 1'b0;
   logic [3:0]  evt_iac = '0;
   logic [1:0]  evt_dac_rd = '0, evt_dac_wr = '0;
   logic        spr_priv = 1'b0, spr_rd = 1'b0, spr_wr = 1'b0;
   logic [9:0]  spr_num = '0;
   logic [31:0] spr_wdata = '0;
   logic [31:0] spr_rdata;
   logic        priv_viol;

   int unsigned n_vec = 0, n_bad = 0;
   bit          done = 1'b0;
   logic [31:0] model = '0;
   logic        exp_viol = 1'b0;

   always #2.5 clk = ~clk;

   dbg_event_status u_dut (
      .clk(clk), .rst_n(rst_n), .rst_cause(rst_cause), .dbg_en(dbg_en),
      .evt_iac(evt_iac), .evt_dac_rd(evt_dac_rd), .evt_dac_wr(evt_dac_wr),
      .spr_priv(spr_priv), .spr_rd(spr_rd), .spr_wr(spr_wr),
      .spr_num(spr_num), .spr_wdata(spr_wdata),
      .spr_rdata(spr_rdata), .priv_viol(priv_viol)
   );

   function automatic logic [31:0] set_of(input logic [3:0] iac, input logic [1:0] rd,
                                          input logic [1:0] wr, input logic en);
      logic [31:0] s = '0;
      s[26] = iac[0]; s[25] = iac[1]; s[19] = iac[2]; s[18] = iac[3];
      s[24] = rd[0];  s[23] = wr[0];  s[22] = rd[1];  s[21] = wr[1];
      s[20] = (|{iac, rd, wr}) & ~en;
      return s;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic [3:0] iac, input logic [1:0] rd, input logic [1:0] wr,
                       input logic en, input logic pr, input logic r, input logic w,
                       input logic [9:0] num, input logic [31:0] wd, input string req);
      logic [31:0] clr;
      @(negedge clk);
      evt_iac = iac; evt_dac_rd = rd; evt_dac_wr = wr; dbg_en = en;
      spr_priv = pr; spr_rd = r; spr_wr = w; spr_num = num; spr_wdata = wd;
      #1;
      // R1 R10: combinational read of the pre-update value
      check(req, spr_rdata, (r && pr && num == ADDR) ? model : 32'h0);
      // R8: pulse from the previous access
      check("R8", {31'h0, priv_viol}, {31'h0, exp_viol});
      clr = (w && pr && num == ADDR) ? (wd & IMPL) : 32'h0;
      model = (model & ~clr) | set_of(iac, rd, wr, en);
      exp_viol = (num == ADDR) && (r || w) && !pr;
   endtask

   task automatic do_reset(input logic [1:0] cause);
      @(negedge clk);
      rst_n = 1'b0; rst_cause = cause;
      evt_iac = '0; evt_dac_rd = '0; evt_dac_wr = '0; spr_rd = 0; spr_wr = 0;
      @(negedge clk);
      rst_n = 1'b1;
      model = {22'h0, cause, 8'h0};
      exp_viol = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      // R7: each reset code, read back right after reset
      for (int c = 0; c < 4; c++) begin
         do_reset(2'(c));
         step('0, '0, '0, 1, 1, 1, 0, ADDR, '0, "R7");
      end
      // R3: each event alone, with debug enabled
      for (int i = 0; i < 4; i++) begin
         step(4'(1 << i), '0, '0, 1, 1, 0, 0, ADDR, '0, "R3");
         step('0, '0, '0, 1, 1, 1, 0, ADDR, '0, "R3");
      end
      step('0, 2'b11, 2'b11, 1, 1, 0, 0, ADDR, '0, "R3");
      step('0, '0, '0, 1, 1, 1, 0, ADDR, '0, "R6");   // R6: imprecise stays 0
      // R2 R4: clear everything with all-ones mask, then a set-free write
      step('0, '0, '0, 1, 1, 0, 1, ADDR, 32'hFFFF_FFFF, "R4");
      step('0, '0, '0, 1, 1, 1, 0, ADDR, '0, "R2");
      // R6: event with debug disabled sets imprecise
      step(4'b0100, '0, '0, 0, 1, 0, 0, ADDR, '0, "R6");
      step('0, '0, '0, 1, 1, 1, 0, ADDR, '0, "R6");
      // R5: clear and set on the same bit together
      step(4'b0100, '0, '0, 1, 1, 0, 1, ADDR, 32'h0008_0000, "R5");
      step('0, '0, '0, 1, 1, 1, 0, ADDR, '0, "R5");
      // R8: unprivileged clear and read, then privileged read
      step('0, '0, '0, 1, 0, 1, 1, ADDR, 32'hFFFF_FFFF, "R8");
      step('0, '0, '0, 1, 1, 1, 0, ADDR, '0, "R8");
      // R9: privileged clear to another number
      step('0, '0, '0, 1, 1, 0, 1, 10'd1009, 32'hFFFF_FFFF, "R9");
      step('0, '0, '0, 1, 1, 1, 0, ADDR, '0, "R9");
      // R10: read and clear in the same cycle
      step('0, '0, '0, 1, 1, 1, 1, ADDR, 32'hFFFF_FFFF, "R10");
      step('0, '0, '0, 1, 1, 1, 0, ADDR, '0, "R10");
      // Constrained random mix
      for (int k = 0; k < 4000; k++) begin
         logic [3:0] iac; logic [1:0] rd, wr; logic [9:0] num;
         if (k % 700 == 699) begin
            do_reset(2'($urandom_range(0, 3)));
            continue;
         end
         iac = 4'($urandom) & 4'($urandom) & 4'($urandom);
         rd  = 2'($urandom) & 2'($urandom) & 2'($urandom);
         wr  = 2'($urandom) & 2'($urandom) & 2'($urandom);
         num = ($urandom_range(0, 7) == 0) ? 10'($urandom) : ADDR;
         step(iac, rd, wr, 1'($urandom), ($urandom_range(0, 7) != 0),
              ($urandom_range(0, 3) != 0), ($urandom_range(0, 3) == 0), num,
              $urandom, "R1");
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule